// File: doc/BRIEF.md
# Binary Arithmetic Encoder

The block turns a stream of binary events into a compressed serial bit stream. A 16-bit coding interval, held as an inclusive lower and upper bound, starts at the full range. For each event the caller supplies the probability that the event is a 0. The block splits the interval in that ratio and keeps the part that belongs to the event that occurred. Likely events shrink the interval only a little and cost a fraction of a bit. Unlikely events shrink it a lot and push out several bits.

Once the interval has narrowed, the block renormalizes it one step per clock. A leading bit that both bounds share is settled: the block emits it and doubles the interval. If the interval sits across the midpoint inside the middle half, the block records a deferred bit and rescales about the midpoint instead. When the next bit is settled, the deferred bits follow it, each inverted. A flush ends the stream with the shortest tail that lies inside the final interval, then returns the block to its starting state.

Events use a valid/ready handshake. Output bits come out one per cycle with a strobe. While renormalization or deferred bits are still pending, the block holds off further input.

Top module: `bin_arith_enc`

## Requirements
- R1: After reset, ready_o=1 and bit_vld_o=0, the interval is the full range (lower 0x0000, upper 0xFFFF) and no deferred bits are held, so a flush issued at once emits exactly the single bit 1.
- R2: prob_i gives the probability of event 0 in units of 2^-16. Event 0 is assigned n0 = floor((upper-lower+1)*prob_i/65536) code values, raised to 1 when that is 0, and event 1 gets the rest.
- R3: For an event 0 (evt_i=0) the interval becomes [lower, lower+n0-1], the lower sub-range. For an event 1 it becomes [lower+n0, upper], the upper sub-range.
- R4: While upper < 0x8000, a 0 is settled and lower=2*lower, upper=2*upper+1. While lower >= 0x8000, a 1 is settled and lower=2*(lower-0x8000), upper=2*(upper-0x8000)+1. On return to ready, upper-lower > 0x4000.
- R5: When lower >= 0x4000 and upper < 0xC000 (and neither R4 case applies), no bit is emitted. The deferred count is incremented, and lower=2*(lower-0x4000), upper=2*(upper-0x4000)+1.
- R6: Each settled bit b is followed, in consecutive output bits, by as many copies of the inverse of b as the deferred count holds. The count is then cleared.
- R7: At most one bit leaves per cycle. An event is taken only when valid_i and ready_o are both high, and valid_i has priority over flush_i. ready_o is low in the cycle after an event is taken, and after a flush while deferred bits remain, until all resulting bits are out.
- R8: A flush (flush_i high, valid_i low, ready_o high) emits a 1 followed by the deferred count of 0 bits. After that the interval is the full range again and the deferred count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Event present |
| evt_i | input | 1 | Event value (0 = first event, lower sub-range) |
| prob_i | input | W | Probability of event 0, scaled by 2^W |
| flush_i | input | 1 | Terminate the stream and restart |
| ready_o | output | 1 | Block accepts an event or flush |
| bit_o | output | 1 | Output bit |
| bit_vld_o | output | 1 | bit_o is valid this cycle |

## Verification
The bench builds the block with W=16 and a 16-bit deferred counter. At this width the extreme probabilities 0x0000 and 0xFFFF squeeze the interval to a single code value, which forces a run of sixteen settled bits. A crafted pair of events leaves exactly one deferred bit, so both the release rule and the flush tail can be predicted by hand. A long pseudo-random run with varied probabilities then drives chains of deferred bits against a reference model written from the requirements.

// File: rtl/bae_pkg.sv
package bae_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_NORM, ST_DRAIN} st_e;
  typedef enum logic [1:0] {RN_DONE, RN_LOW, RN_HIGH, RN_MID} rn_e;
endpackage

// File: rtl/bae_split.sv
module bae_split #(
  parameter int W = 16
) (
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] prob_i,
  input  logic         evt_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  localparam int PW = 2 * W + 1;

  logic [W:0]   span;
  logic [PW-1:0] prod;
  logic [W:0]   n0_raw;
  logic [W-1:0] frac_unused;
  logic [W-1:0] n0;

  assign span = {1'b0, hi_i} - {1'b0, lo_i} + (W+1)'(1);
  assign prod = {{W{1'b0}}, span} * {{(W+1){1'b0}}, prob_i};
  assign {n0_raw, frac_unused} = prod;
  // event 1 always keeps >= 1 value since n0_raw < span
  assign n0 = (n0_raw == '0) ? W'(1) : n0_raw[W-1:0];

  assign lo_o = evt_i ? lo_i + n0 : lo_i;
  assign hi_o = evt_i ? hi_i : lo_i + n0 - W'(1);
endmodule

// File: rtl/bae_renorm.sv
module bae_renorm
  import bae_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output rn_e          kind_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  always_comb begin
    kind_o = RN_DONE;
    lo_o   = lo_i;
    hi_o   = hi_i;
    if (!hi_i[W-1]) begin
      kind_o = RN_LOW;
      lo_o   = {lo_i[W-2:0], 1'b0};
      hi_o   = {hi_i[W-2:0], 1'b1};
    end else if (lo_i[W-1]) begin
      kind_o = RN_HIGH;
      lo_o   = {lo_i[W-2:0], 1'b0};
      hi_o   = {hi_i[W-2:0], 1'b1};
    end else if (lo_i[W-2] && !hi_i[W-2]) begin
      // straddles midpoint inside middle half: rescale about it
      kind_o = RN_MID;
      lo_o   = {1'b0, lo_i[W-3:0], 1'b0};
      hi_o   = {1'b1, hi_i[W-3:0], 1'b1};
    end
  end
endmodule

// File: rtl/bin_arith_enc.sv
module bin_arith_enc
  import bae_pkg::*;
#(
  parameter int W      = 16,
  parameter int PEND_W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         evt_i,
  input  logic [W-1:0] prob_i,
  input  logic         flush_i,
  output logic         ready_o,
  output logic         bit_o,
  output logic         bit_vld_o
);
  st_e               st_q;
  logic [W-1:0]      lo_q, hi_q;
  logic [PEND_W-1:0] pend_q;
  logic              opp_q, fin_q, bit_q, bvld_q;

  logic [W-1:0] sp_lo, sp_hi, rn_lo, rn_hi;
  rn_e          rn_kind;

  bae_split #(.W(W)) u_split (
    .lo_i(lo_q), .hi_i(hi_q), .prob_i(prob_i), .evt_i(evt_i),
    .lo_o(sp_lo), .hi_o(sp_hi)
  );

  bae_renorm #(.W(W)) u_renorm (
    .lo_i(lo_q), .hi_i(hi_q), .kind_o(rn_kind),
    .lo_o(rn_lo), .hi_o(rn_hi)
  );

  assign ready_o   = (st_q == ST_IDLE);
  assign bit_o     = bit_q;
  assign bit_vld_o = bvld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      lo_q   <= '0;
      hi_q   <= '1;
      pend_q <= '0;
      opp_q  <= 1'b0;
      fin_q  <= 1'b0;
      bit_q  <= 1'b0;
      bvld_q <= 1'b0;
    end else begin
      bvld_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (valid_i) begin
            lo_q <= sp_lo;
            hi_q <= sp_hi;
            st_q <= ST_NORM;
          end else if (flush_i) begin
            bit_q  <= 1'b1;
            bvld_q <= 1'b1;
            if (pend_q != '0) begin
              opp_q <= 1'b0;
              fin_q <= 1'b1;
              st_q  <= ST_DRAIN;
            end else begin
              lo_q <= '0;
              hi_q <= '1;
            end
          end
        end
        ST_NORM: begin
          unique case (rn_kind)
            RN_LOW, RN_HIGH: begin
              bit_q  <= (rn_kind == RN_HIGH);
              bvld_q <= 1'b1;
              lo_q   <= rn_lo;
              hi_q   <= rn_hi;
              if (pend_q != '0) begin
                opp_q <= (rn_kind == RN_LOW);
                st_q  <= ST_DRAIN;
              end
            end
            RN_MID: begin
              pend_q <= pend_q + PEND_W'(1);
              lo_q   <= rn_lo;
              hi_q   <= rn_hi;
            end
            default: st_q <= ST_IDLE;
          endcase
        end
        ST_DRAIN: begin
          bit_q  <= opp_q;
          bvld_q <= 1'b1;
          pend_q <= pend_q - PEND_W'(1);
          if (pend_q == PEND_W'(1)) begin
            if (fin_q) begin
              lo_q  <= '0;
              hi_q  <= '1;
              fin_q <= 1'b0;
              st_q  <= ST_IDLE;
            end else begin
              st_q <= ST_NORM;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bae_chk.sv
module bae_chk #(
  parameter int W      = 16,
  parameter int PEND_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              flush_i,
  input logic              ready_o,
  input logic [W-1:0]      lo_i,
  input logic [W-1:0]      hi_i,
  input logic [PEND_W-1:0] pend_i
);
  localparam logic [W-1:0] QTR = {2'b01, {(W-2){1'b0}}};

  // R7
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !ready_o);

  // R3
  interval_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_i <= hi_i);

  // R4
  idle_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!lo_i[W-1] && hi_i[W-1] && (hi_i - lo_i) > QTR));

  // R8
  flush_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !valid_i && flush_i && pend_i == '0 |=> lo_i == '0 && hi_i == '1);

  // R6
  drained_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !valid_i && flush_i |=> pend_i == '0 || !ready_o);
endmodule

bind bin_arith_enc bae_chk #(.W(W), .PEND_W(PEND_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .flush_i(flush_i),
  .ready_o(ready_o), .lo_i(lo_q), .hi_i(hi_q), .pend_i(pend_q)
);

// File: tb/sim_bin_arith_enc.sv
module sim_bin_arith_enc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0, evt_i = 1'b0, flush_i = 1'b0;
  logic [15:0] prob_i = '0;
  logic ready_o, bit_o, bit_vld_o;

  always #2.5 clk = ~clk;

  bin_arith_enc #(.W(16), .PEND_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .evt_i(evt_i),
    .prob_i(prob_i), .flush_i(flush_i), .ready_o(ready_o),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o)
  );

  typedef struct {logic b; string tag;} exp_t;
  exp_t exp_q[$];
  int tests = 0, fails = 0;
  int m_lo = 0, m_hi = 65535, m_pend = 0;
  string cur_tag = "R1";
  bit finished = 0;
  logic [31:0] lf = 32'h1234_5678;

  task automatic check(input string tag, input logic act, input logic expv, input string what);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, expv);
    end
  endtask

  task automatic push_settled(input logic b);
    exp_q.push_back('{b, cur_tag});
    repeat (m_pend) exp_q.push_back('{~b, cur_tag});
    m_pend = 0;
  endtask

  task automatic model_evt(input logic e, input logic [15:0] p);
    longint span, n0;
    span = longint'(m_hi - m_lo + 1);
    n0 = (span * longint'(p)) >> 16;
    if (n0 == 0) n0 = 1;
    if (!e) m_hi = m_lo + int'(n0) - 1;
    else    m_lo = m_lo + int'(n0);
    while (1) begin
      if (m_hi < 32768) begin
        push_settled(1'b0); m_lo = 2 * m_lo; m_hi = 2 * m_hi + 1;
      end else if (m_lo >= 32768) begin
        push_settled(1'b1); m_lo = 2 * (m_lo - 32768); m_hi = 2 * (m_hi - 32768) + 1;
      end else if (m_lo >= 16384 && m_hi < 49152) begin
        m_pend++; m_lo = 2 * (m_lo - 16384); m_hi = 2 * (m_hi - 16384) + 1;
      end else break;
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!ready_o) @(negedge clk);
  endtask

  task automatic send(input logic e, input logic [15:0] p);
    model_evt(e, p);
    wait_ready();
    valid_i = 1'b1; evt_i = e; prob_i = p;
    flush_i = 1'b1; // valid_i must win over flush_i
    @(negedge clk);
    valid_i = 1'b0; flush_i = 1'b0;
    check("R7", ready_o, 1'b0, "ready after accept");
  endtask

  task automatic flush();
    int had;
    had = m_pend;
    push_settled(1'b1);
    m_lo = 0; m_hi = 65535;
    wait_ready();
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    if (had > 0) check("R7", ready_o, 1'b0, "ready during flush drain");
  endtask

  task automatic drain_check(input string tag);
    wait_ready();
    repeat (4) @(negedge clk);
    check(tag, 1'b1, (exp_q.size() == 0), "all expected bits seen");
  endtask

  always @(negedge clk) begin
    if (rst_n && bit_vld_o) begin
      exp_t x;
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected bit: actual %0b expected none", cur_tag, bit_o);
      end else begin
        x = exp_q.pop_front();
        if (bit_o !== x.b) begin
          fails++;
          $display("FAIL %s stream bit: actual %0b expected %0b", x.tag, bit_o, x.b);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and bare flush
    check("R1", ready_o, 1'b1, "ready after reset");
    check("R1", bit_vld_o, 1'b0, "no bit after reset");
    cur_tag = "R1";
    flush();
    drain_check("R1");

    // R2 clamp at both probability extremes
    cur_tag = "R2";
    send(1'b0, 16'h0000);
    send(1'b1, 16'hFFFF);
    send(1'b0, 16'hF333);
    drain_check("R2");

    // R3 sub-range choice
    cur_tag = "R3";
    send(1'b1, 16'h8000);
    send(1'b0, 16'h4000);
    send(1'b1, 16'hC000);
    drain_check("R3");

    // R5 exactly one deferred bit, then R8 flush tail 1,0
    cur_tag = "R5";
    flush();
    send(1'b1, 16'h4000);
    send(1'b0, 16'hAAAB);
    cur_tag = "R8";
    flush();
    drain_check("R8");
    cur_tag = "R8";
    flush();
    drain_check("R8");

    // R6 deferred bit released after a settled bit
    cur_tag = "R6";
    send(1'b1, 16'h4000);
    send(1'b0, 16'hAAAB);
    send(1'b0, 16'h2000);
    drain_check("R6");

    // R4 pseudo-random run
    cur_tag = "R4";
    for (int i = 0; i < 400; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      send(lf[31:16] >= lf[15:0], lf[15:0]);
    end
    flush();
    drain_check("R4");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule